// File: doc/BRIEF.md
# Null Filler Packet Generator

This block builds one long packet of the null (filler) type for a display serial link. The packet goes out as a stream of bytes over a valid/ready handshake. A one-cycle start pulse captures the configuration: a 2-bit virtual channel, a 2-bit payload length of zero to three bytes, and two enable bits. One enable controls the header error-correction byte and the other controls the payload checksum.

The block computes the header Hamming code from the first three header bytes. It folds each payload byte into a 16-bit CRC as the byte leaves, so the checksum is ready when the payload ends. After the last checksum byte is accepted, the block raises a one-cycle done pulse and will take a new start.

Top module: `nullpkt_gen`

## Requirements
- R1: A packet with payload length N (0 to 3) has exactly 4 + N + 2 bytes, in this order: identifier, count low, count high, ECC, N payload bytes, CRC low byte, CRC high byte.
- R2: The identifier byte is {vc[1:0], 6'h09}, with the channel in bits 7:6. Channel 3 gives 0xC9.
- R3: The count low byte equals N and the count high byte is 0x00.
- R4: With ECC enabled, the ECC byte has bits 7:6 at zero. Bits 5:0 hold the 6-bit Hamming parity P0..P5 over D[23:0] = {count high, count low, identifier}, where D0 is bit 0 of the identifier. With ECC disabled, the byte is 0x00.
- R5: Every payload byte is 0x00.
- R6: With the checksum enabled, the CRC is CRC-16 with reflected polynomial 0x8408 and seed 0xFFFF, taken LSB first with no final inversion. For N = 0, 1, 2 and 3 it is 0xFFFF, 0x0F87, 0xF0B8 and 0x3933, and it is sent low byte first.
- R7: With the checksum disabled, both CRC bytes are 0x00.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change. The stream advances one byte per accepted transfer.
- R9: done is high for exactly one cycle: the cycle after the final CRC byte is accepted. busy is low in that cycle and out_valid falls at the same time.
- R10: The configuration is captured at start. Input changes and start pulses while busy have no effect on the current packet and do not trigger another one.
- R11: After reset, out_valid, busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a packet (taken only when idle) |
| vc | input | 2 | Virtual channel |
| psize | input | 2 | Payload length in bytes |
| ecc_en | input | 1 | Generate the header ECC |
| crc_en | input | 1 | Generate the payload CRC |
| out_data | output | 8 | Packet byte |
| out_valid | output | 1 | out_data holds a byte |
| out_ready | input | 1 | Sink accepts the byte |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle end-of-packet pulse |

## Verification
A start taken at a clock edge puts the identifier byte on out_data with out_valid high right after that edge. Each byte accepted at an edge is replaced by the next one right after that edge. done appears in the cycle after the edge that accepts the final CRC byte. The bench drives inputs at the falling edge and reads outputs just after it, so each check sees the value the last rising edge registered. The end-of-packet checks are placed exactly one cycle after the final acceptance.

// File: rtl/nullpkt_gen.sv
module nullpkt_gen #(
  parameter int VC_W = 2,
  parameter int SZ_W = 2,
  parameter logic [5:0] DTYPE = 6'h09
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VC_W-1:0] vc,
  input  logic [SZ_W-1:0] psize,
  input  logic            ecc_en,
  input  logic            crc_en,
  output logic [7:0]      out_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            busy,
  output logic            done
);
  localparam int MAXN  = (1 << SZ_W) - 1;
  localparam int HDR   = 4;
  localparam int IDX_W = $clog2(HDR + MAXN + 2 + 1);

  logic [IDX_W-1:0] idx;
  logic [VC_W-1:0]  vc_q;
  logic [SZ_W-1:0]  n_q;
  logic             ecc_q, crc_q;
  logic [15:0]      crc;
  logic [IDX_W-1:0] pay_end, last_idx;
  logic [23:0]      hd;
  logic [5:0]       ecc;
  logic             fire;

  assign out_valid = busy;
  assign fire      = out_valid & out_ready;
  assign pay_end   = IDX_W'(HDR) + IDX_W'(n_q);
  assign last_idx  = pay_end + IDX_W'(1);
  assign hd        = {8'h00, 8'(n_q), {vc_q, DTYPE}};

  assign ecc[0] = hd[0]^hd[1]^hd[2]^hd[4]^hd[5]^hd[7]^hd[10]^hd[11]^hd[13]^hd[16]^hd[20]^hd[21]^hd[22]^hd[23];
  assign ecc[1] = hd[0]^hd[1]^hd[3]^hd[4]^hd[6]^hd[8]^hd[10]^hd[12]^hd[14]^hd[17]^hd[20]^hd[21]^hd[22]^hd[23];
  assign ecc[2] = hd[0]^hd[2]^hd[3]^hd[5]^hd[6]^hd[9]^hd[11]^hd[12]^hd[15]^hd[18]^hd[20]^hd[21]^hd[22];
  assign ecc[3] = hd[1]^hd[2]^hd[3]^hd[7]^hd[8]^hd[9]^hd[13]^hd[14]^hd[15]^hd[19]^hd[20]^hd[21]^hd[23];
  assign ecc[4] = hd[4]^hd[5]^hd[6]^hd[7]^hd[8]^hd[9]^hd[16]^hd[17]^hd[18]^hd[19]^hd[20]^hd[22]^hd[23];
  assign ecc[5] = hd[10]^hd[11]^hd[12]^hd[13]^hd[14]^hd[15]^hd[16]^hd[17]^hd[18]^hd[19]^hd[21]^hd[22]^hd[23];

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ 16'h8408;
      else             r = r >> 1;
    end
    return r;
  endfunction

  always_comb begin
    if (idx == IDX_W'(0))      out_data = hd[7:0];
    else if (idx == IDX_W'(1)) out_data = hd[15:8];
    else if (idx == IDX_W'(2)) out_data = hd[23:16];
    else if (idx == IDX_W'(3)) out_data = ecc_q ? {2'b00, ecc} : 8'h00;
    else if (idx < pay_end)    out_data = 8'h00;
    else if (idx == pay_end)   out_data = crc_q ? crc[7:0] : 8'h00;
    else                       out_data = crc_q ? crc[15:8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      idx   <= '0;
      vc_q  <= '0;
      n_q   <= '0;
      ecc_q <= 1'b0;
      crc_q <= 1'b0;
      crc   <= 16'hFFFF;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          idx   <= '0;
          vc_q  <= vc;
          n_q   <= psize;
          ecc_q <= ecc_en;
          crc_q <= crc_en;
          crc   <= 16'hFFFF;
        end
      end else if (fire) begin
        if (idx >= IDX_W'(HDR) && idx < pay_end) crc <= crc_byte(crc, out_data);
        if (idx == last_idx) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + IDX_W'(1);
        end
      end
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(fire));

  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable({vc_q, n_q, ecc_q, crc_q}));

  p_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> idx <= last_idx);

  p_ecc_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && idx == IDX_W'(3) |-> out_data[7:6] == 2'b00);
endmodule

// File: tb/nullpkt_gen_test.sv
module nullpkt_gen_test;
  logic clk = 0, rst_n = 0, start = 0, ecc_en = 0, crc_en = 0, out_ready = 0;
  logic [1:0] vc = 0, psize = 0;
  logic [7:0] out_data;
  logic out_valid, busy, done;
  int checks = 0, fails = 0;
  bit timed_out = 0;

  always #2 clk = ~clk;

  nullpkt_gen uut (.clk(clk), .rst_n(rst_n), .start(start), .vc(vc), .psize(psize),
    .ecc_en(ecc_en), .crc_en(crc_en), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .busy(busy), .done(done));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] ecc_ref(input logic [23:0] d);
    logic [23:0] m [6] = '{24'hF12CB7, 24'hF2555B, 24'h749A6D, 24'hB8E38E, 24'hDF03F0, 24'hEFFC00};
    logic [5:0] p;
    for (int i = 0; i < 6; i++) p[i] = ^(d & m[i]);
    return p;
  endfunction

  function automatic logic [15:0] crc_ref(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < n * 8; k++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    return c;
  endfunction

  task automatic run_pkt(input logic [1:0] v, input logic [1:0] n, input bit e, input bit c,
                         input int stall, input bit poke);
    logic [7:0] exp [9];
    int len = 6 + int'(n);
    int got = 0, cyc = 0;
    bit hold = 0;
    logic [7:0] prev = 0;
    logic [15:0] cr = c ? crc_ref(int'(n)) : 16'h0000;
    exp[0] = {v, 6'h09};
    exp[1] = {6'd0, n};
    exp[2] = 8'h00;
    exp[3] = e ? {2'b00, ecc_ref({8'h00, 6'd0, n, v, 6'h09})} : 8'h00;
    for (int i = 0; i < 3; i++) exp[4 + i] = 8'h00;
    exp[4 + n] = cr[7:0];
    exp[5 + n] = cr[15:8];
    @(negedge clk);
    start = 1; vc = v; psize = n; ecc_en = e; crc_en = c;
    @(negedge clk);
    start = 0; vc = ~v; psize = ~n; ecc_en = ~e; crc_en = ~c;
    while (got < len && cyc < 100) begin
      out_ready = (stall == 0) ? 1'b1 : ((cyc % stall) != 0);
      start = poke && (cyc == 3);
      #1;
      check(out_valid, "R1 valid during packet", out_valid, 1);
      if (hold) check(out_data == prev, "R8 hold under stall", out_data, prev);
      if (out_ready) begin
        check(out_data == exp[got],
              got == 0 ? "R2 identifier" : got < 3 ? "R3 count" : got == 3 ? "R4 ecc" :
              got < 4 + n ? "R5 payload" : (c ? "R6 crc" : "R7 crc off"), out_data, exp[got]);
        got++;
      end
      hold = !out_ready;
      prev = out_data;
      cyc++;
      @(negedge clk);
    end
    out_ready = 0; start = 0;
    #1;
    check(done && !busy && !out_valid, "R9 done after last byte", {done, busy, out_valid}, 3'b100);
    @(negedge clk);
    #1;
    check(!done && !out_valid, "R10/R9 no restart, single pulse", {done, out_valid}, 2'b00);
  endtask

  task automatic t_reset;
    #1;
    check(!out_valid && !busy && !done, "R11 reset state", {out_valid, busy, done}, 0);
  endtask

  task automatic t_lengths;
    for (int n = 0; n < 4; n++) run_pkt(2'(n), 2'(n), 1, 1, 0, 0);
    check(crc_ref(0) == 16'hFFFF && crc_ref(1) == 16'h0F87 && crc_ref(2) == 16'hF0B8
          && crc_ref(3) == 16'h3933, "R6 checksum constants", crc_ref(3), 16'h3933);
  endtask

  task automatic t_channel3;
    run_pkt(2'd3, 2'd2, 1, 1, 0, 0);
  endtask

  task automatic t_disabled;
    run_pkt(2'd1, 2'd3, 0, 0, 0, 0);
    run_pkt(2'd2, 2'd0, 0, 1, 0, 0);
  endtask

  task automatic t_backpressure;
    run_pkt(2'd1, 2'd1, 1, 1, 2, 0);
    run_pkt(2'd0, 2'd3, 1, 0, 3, 0);
  endtask

  task automatic t_start_busy;
    run_pkt(2'd2, 2'd3, 1, 1, 0, 1);
  endtask

  initial begin
    t_reset;
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_lengths;
    t_channel3;
    t_disabled;
    t_backpressure;
    t_start_busy;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #40000;
    timed_out = 1;
    checks++; fails++;
    $display("FAIL watchdog actual=0x1 expected=0x0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule